// File: doc/BRIEF.md
# Step Condition Decoder

This block decides whether one condition of one sequencer step is true. Each condition is a programmable product term. The sources are the AND and OR results of up to four priority groups, a timer comparator flag and an event-counter comparator flag. A 32-bit decode word gives every source two bits:

- an inclusion bit, which pulls the source into the product term;
- a level bit, which gives the value the source must show.

A final inversion bit can flip the result. The output, a single condition-true flag, goes to the step sequencer.

The decoder is pure combinational logic. A parameter can add a one-cycle output register, which has a synchronous active-high reset. The flag then lines up with the other registered state of the sequencer. The comparators and the action selection live outside this block.

Top module: `step_cond_decode`

## Requirements
- R1: For priority group n (n = 0..3), decode bit 4n+1 includes that group's AND result, and decode bit 4n gives the level the AND result must have. A word of 0x3 is true when the AND result of group 0 is 1, and 0x30 is true when the AND result of group 1 is 1.
- R2: For priority group n, decode bit 4n+3 includes that group's OR result, and decode bit 4n+2 gives the level the OR result must have.
- R3: Decode bit 17 includes the timer comparator flag, and decode bit 16 gives its required level. A word of 0x30000 is true exactly when the timer flag is 1.
- R4: Decode bit 21 includes the counter comparator flag, and decode bit 20 gives its required level.
- R5: Decode bit 24 inverts the decoded result before it reaches the output.
- R6: Before inversion, the condition is true only when every included source equals its required level. A source that is not included has no effect on the output, whatever its value and whatever its level bit.
- R7: When no source is included, the result before inversion is 0. The output then equals decode bit 24, whatever the level bits and inputs are.
- R8: Decode bits 18, 19, 22, 23 and 25 to 31 have no effect on the output.
- R9: With REG_OUT = 1, the output is 0 in the cycle after a clock edge at which rst is high. After reset, the output shows the decoded value of the inputs present at the previous rising clock edge.
- R10: With REG_OUT = 0, the output follows the inputs and the decode word in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| grp_and_i | input | NUM_GRP | AND result of each priority group |
| grp_or_i | input | NUM_GRP | OR result of each priority group |
| timer_hit_i | input | 1 | Timer comparator flag |
| count_hit_i | input | 1 | Event-counter comparator flag |
| decode_word_i | input | 32 | Condition decode word |
| cond_true_o | output | 1 | Condition-true flag to the step sequencer |

## Verification
The hardest case to reach is a mismatch on exactly one included source when several sources are included, with every excluded source at a value that would break the term if it counted. A random decode word seldom includes the right mix. The bench therefore holds each decode word fixed and sweeps all 1024 combinations of the ten source inputs under it. It uses directed words for the single-source encodings and for words that include nothing, plus shaped pseudo-random words whose inclusion bits are thinned, so that product terms with two to four sources occur often. The registered and the combinational variants see the same stimulus, which exposes any one-cycle slip.

// File: rtl/step_cond_pkg.sv
`timescale 1ns/1ps
package step_cond_pkg;

    localparam int DECODE_W    = 32;
    localparam int GRP_MAX     = 4;
    localparam int TMR_LVL_BIT = 16;
    localparam int TMR_ACT_BIT = 17;
    localparam int CNT_LVL_BIT = 20;
    localparam int CNT_ACT_BIT = 21;
    localparam int INV_BIT     = 24;

    // Control pair for one source of the product term
    typedef struct packed {
        logic active;
        logic level;
    } src_ctl_t;

    function automatic src_ctl_t grp_and_ctl(logic [DECODE_W-1:0] w, int n);
        src_ctl_t c;
        c.active = w[4*n+1];
        c.level  = w[4*n];
        return c;
    endfunction

    function automatic src_ctl_t grp_or_ctl(logic [DECODE_W-1:0] w, int n);
        src_ctl_t c;
        c.active = w[4*n+3];
        c.level  = w[4*n+2];
        return c;
    endfunction

    function automatic src_ctl_t tmr_ctl(logic [DECODE_W-1:0] w);
        src_ctl_t c;
        c.active = w[TMR_ACT_BIT];
        c.level  = w[TMR_LVL_BIT];
        return c;
    endfunction

    function automatic src_ctl_t cnt_ctl(logic [DECODE_W-1:0] w);
        src_ctl_t c;
        c.active = w[CNT_ACT_BIT];
        c.level  = w[CNT_LVL_BIT];
        return c;
    endfunction

    // Bits of the decode word that carry meaning for a given group count
    function automatic logic [DECODE_W-1:0] used_mask(int ngrp);
        logic [DECODE_W-1:0] m;
        m = '0;
        for (int g = 0; g < ngrp; g++) m[4*g +: 4] = 4'hF;
        m[TMR_LVL_BIT] = 1'b1;
        m[TMR_ACT_BIT] = 1'b1;
        m[CNT_LVL_BIT] = 1'b1;
        m[CNT_ACT_BIT] = 1'b1;
        m[INV_BIT]     = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/src_match.sv
`timescale 1ns/1ps
module src_match
    import step_cond_pkg::*;
(
    input  logic     val_i,
    input  src_ctl_t ctl_i,
    output logic     hit_o,
    output logic     used_o
);

    // An excluded source always passes; an included one must equal its level
    always_comb begin
        used_o = ctl_i.active;
        hit_o  = ctl_i.active ? (val_i == ctl_i.level) : 1'b1;
    end

endmodule

// File: rtl/term_reduce.sv
`timescale 1ns/1ps
module term_reduce #(
    parameter int NUM_SRC = 10
) (
    input  logic [NUM_SRC-1:0] hit_i,
    input  logic [NUM_SRC-1:0] used_i,
    output logic               pre_o
);

    logic any_used;
    logic all_hit;

    always_comb begin
        any_used = |used_i;
        all_hit  = &hit_i;
        pre_o    = any_used && all_hit;
    end

    always_comb begin
        if (|(used_i & ~hit_i)) begin
            AST_MISMATCH_KILLS: assert (!pre_o); // R6
        end
        if (used_i == '0) begin
            AST_EMPTY_IS_FALSE: assert (!pre_o); // R7
        end
    end

endmodule

// File: rtl/cond_out_stage.sv
`timescale 1ns/1ps
module cond_out_stage #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pre_i,
    input  logic inv_i,
    output logic cond_o
);

    logic flag_d;
    assign flag_d = pre_i ^ inv_i;

    generate
        if (REG_OUT) begin : g_reg
            logic flag_q;
            logic seen_rst_q;

            always_ff @(posedge clk) begin
                if (rst) flag_q <= 1'b0;
                else     flag_q <= flag_d;
            end
            assign cond_o = flag_q;

            always_ff @(posedge clk) begin
                if (rst) seen_rst_q <= 1'b1;
            end

            AST_RESET_CLEARS: assert property (@(posedge clk)
                rst |=> !cond_o); // R9
            AST_ONE_CYCLE_LAG: assert property (@(posedge clk) disable iff (rst)
                (seen_rst_q && !$past(rst)) |-> (cond_o == $past(flag_d))); // R9
        end else begin : g_comb
            assign cond_o = flag_d;
        end
    endgenerate

endmodule

// File: rtl/step_cond_decode.sv
`timescale 1ns/1ps
module step_cond_decode
    import step_cond_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GRP-1:0]  grp_and_i,
    input  logic [NUM_GRP-1:0]  grp_or_i,
    input  logic                timer_hit_i,
    input  logic                count_hit_i,
    input  logic [DECODE_W-1:0] decode_word_i,
    output logic                cond_true_o
);

    localparam int NUM_SRC = 2 * NUM_GRP + 2;
    localparam int TMR_IDX = NUM_SRC - 2;
    localparam int CNT_IDX = NUM_SRC - 1;
    localparam logic [DECODE_W-1:0] USED_BITS = used_mask(NUM_GRP);

    src_ctl_t [NUM_SRC-1:0] ctl;
    logic     [NUM_SRC-1:0] val;
    logic     [NUM_SRC-1:0] hit;
    logic     [NUM_SRC-1:0] used;
    logic                   pre_true;
    logic                   unused_bits;

    assign unused_bits = ^(decode_word_i & ~USED_BITS);

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign ctl[2*g]   = grp_and_ctl(decode_word_i, g);
            assign val[2*g]   = grp_and_i[g];
            assign ctl[2*g+1] = grp_or_ctl(decode_word_i, g);
            assign val[2*g+1] = grp_or_i[g];
        end
    endgenerate

    assign ctl[TMR_IDX] = tmr_ctl(decode_word_i);
    assign val[TMR_IDX] = timer_hit_i;
    assign ctl[CNT_IDX] = cnt_ctl(decode_word_i);
    assign val[CNT_IDX] = count_hit_i;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            src_match u_match (
                .val_i  (val[s]),
                .ctl_i  (ctl[s]),
                .hit_o  (hit[s]),
                .used_o (used[s])
            );
        end
    endgenerate

    term_reduce #(.NUM_SRC(NUM_SRC)) u_reduce (
        .hit_i  (hit),
        .used_i (used),
        .pre_o  (pre_true)
    );

    cond_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk    (clk),
        .rst    (rst),
        .pre_i  (pre_true),
        .inv_i  (decode_word_i[INV_BIT]),
        .cond_o (cond_true_o)
    );

endmodule

// File: tb/step_cond_decode_tb_top.sv
`timescale 1ns/1ps
module step_cond_decode_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ga = '0;
    logic [3:0]  go = '0;
    logic        th = 1'b0;
    logic        ch = 1'b0;
    logic [31:0] dw = '0;
    logic        q_reg;
    logic        q_comb;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    step_cond_decode #(.NUM_GRP(4), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .grp_and_i(ga), .grp_or_i(go),
        .timer_hit_i(th), .count_hit_i(ch), .decode_word_i(dw),
        .cond_true_o(q_reg)
    );

    step_cond_decode #(.NUM_GRP(4), .REG_OUT(1'b0)) comb_i (
        .clk(clk), .rst(rst), .grp_and_i(ga), .grp_or_i(go),
        .timer_hit_i(th), .count_hit_i(ch), .decode_word_i(dw),
        .cond_true_o(q_comb)
    );

    // Expected value from the requirements: product of included sources, then bit 24
    function automatic bit model(bit [31:0] w, bit [3:0] a, bit [3:0] o, bit t, bit c);
        int inc = 0;
        bit ok  = 1'b1;
        for (int n = 0; n < 4; n++) begin
            if (w[4*n+1]) begin inc++; if (a[n] != w[4*n])   ok = 1'b0; end
            if (w[4*n+3]) begin inc++; if (o[n] != w[4*n+2]) ok = 1'b0; end
        end
        if (w[17]) begin inc++; if (t != w[16]) ok = 1'b0; end
        if (w[21]) begin inc++; if (c != w[20]) ok = 1'b0; end
        return ((inc > 0) && ok) ^ w[24];
    endfunction

    task automatic chk(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s word=%08h and=%h or=%h t=%b c=%b actual=%b expected=%b",
                     tag, dw, ga, go, th, ch, act, exp);
        end
    endtask

    // Drive one vector, let the register capture it, check both variants
    task automatic apply(input bit [31:0] w, input bit [3:0] a, input bit [3:0] o,
                         input bit t, input bit c, input bit exp, input string tag);
        @(negedge clk);
        dw = w; ga = a; go = o; th = t; ch = c;
        @(posedge clk);
        #1;
        chk(q_comb, exp, tag);
        chk(q_reg,  exp, tag);
    endtask

    task automatic sweep(input bit [31:0] w, input string tag);
        for (int v = 0; v < 1024; v++) begin
            @(negedge clk);
            dw = w; ga = v[3:0]; go = v[7:4]; th = v[8]; ch = v[9];
            @(posedge clk);
            #1;
            chk(q_comb, model(w, v[3:0], v[7:4], v[8], v[9]), tag);
            chk(q_reg,  model(w, v[3:0], v[7:4], v[8], v[9]), tag);
        end
    endtask

    initial begin
        bit [31:0] r1;
        bit [31:0] r2;
        bit [31:0] w;

        // R9: reset state while the inputs decode as true
        dw = 32'h0100_0000;
        repeat (3) @(posedge clk);
        #1;
        chk(q_reg, 1'b0, "R9 reset clears");
        chk(q_comb, 1'b1, "R10 comb during reset");
        @(negedge clk);
        rst = 1'b0;

        // R1
        apply(32'h0000_0003, 4'h1, 4'h0, 0, 0, 1'b1, "R1 g0 and high");
        apply(32'h0000_0003, 4'h0, 4'h0, 0, 0, 1'b0, "R1 g0 and low");
        apply(32'h0000_0030, 4'h2, 4'h0, 0, 0, 1'b1, "R1 g1 and high");
        apply(32'h0000_0002, 4'h0, 4'hF, 1, 1, 1'b1, "R1 g0 level zero");
        apply(32'h0000_3000, 4'h8, 4'h0, 0, 0, 1'b1, "R1 g3 and high");
        // R2
        apply(32'h0000_000C, 4'h0, 4'h1, 0, 0, 1'b1, "R2 g0 or high");
        apply(32'h0000_0008, 4'h0, 4'h1, 0, 0, 1'b0, "R2 g0 or low mismatch");
        apply(32'h0000_C000, 4'h0, 4'h8, 0, 0, 1'b1, "R2 g3 or high");
        // R3
        apply(32'h0003_0000, 4'h0, 4'h0, 1, 0, 1'b1, "R3 timer high");
        apply(32'h0003_0000, 4'h0, 4'h0, 0, 0, 1'b0, "R3 timer low");
        apply(32'h0002_0000, 4'h0, 4'h0, 0, 0, 1'b1, "R3 timer level zero");
        // R4
        apply(32'h0030_0000, 4'h0, 4'h0, 0, 1, 1'b1, "R4 count high");
        apply(32'h0020_0000, 4'h0, 4'h0, 0, 0, 1'b1, "R4 count level zero");
        apply(32'h0020_0000, 4'h0, 4'h0, 0, 1, 1'b0, "R4 count mismatch");
        // R5
        apply(32'h0103_0000, 4'h0, 4'h0, 1, 0, 1'b0, "R5 invert true");
        apply(32'h0103_0000, 4'h0, 4'h0, 0, 0, 1'b1, "R5 invert false");
        // R6
        apply(32'h0000_0033, 4'h1, 4'h0, 0, 0, 1'b0, "R6 one of two mismatch");
        apply(32'h0000_0033, 4'h3, 4'h0, 0, 0, 1'b1, "R6 both match");
        apply(32'h0011_0005, 4'hF, 4'hF, 1, 1, 1'b0, "R7 levels only");
        apply(32'h0015_5557, 4'h1, 4'hA, 0, 1, 1'b1, "R6 excluded ignored");
        // R7
        apply(32'h0000_0000, 4'hF, 4'hF, 1, 1, 1'b0, "R7 empty");
        apply(32'h0100_0000, 4'h0, 4'h0, 0, 0, 1'b1, "R7 empty inverted");
        // R8
        apply(32'hFECC_0003, 4'h1, 4'h0, 0, 0, 1'b1, "R8 spare bits true");
        apply(32'hFECC_0003, 4'h0, 4'h0, 0, 0, 1'b0, "R8 spare bits false");

        // R9 / R10: one-cycle lag of the register, no lag of the combinational path
        apply(32'h0000_0000, 4'h0, 4'h0, 0, 0, 1'b0, "R9 setup");
        @(negedge clk);
        dw = 32'h0100_0000;
        #1;
        chk(q_reg,  1'b0, "R9 register holds old value");
        chk(q_comb, 1'b1, "R10 comb follows at once");
        @(posedge clk);
        #1;
        chk(q_reg,  1'b1, "R9 register updates after edge");
        @(negedge clk);
        dw = 32'h0000_0000;
        #1;
        chk(q_comb, 1'b0, "R10 comb falls at once");
        chk(q_reg,  1'b1, "R9 register still high");

        // Full input sweeps under directed words
        sweep(32'h0000_0000, "R7 sweep empty");
        sweep(32'h0100_0000, "R7 sweep empty inverted");
        sweep(32'h0000_0003, "R1 sweep");
        sweep(32'h0000_00CC, "R2 sweep");
        sweep(32'h0033_0000, "R4 sweep");
        sweep(32'h0132_A0F9, "R5 sweep");
        sweep(32'hFFFF_FFFF, "R8 sweep");

        // Shaped pseudo-random words with thinned inclusion bits
        r1 = 32'h1234_5678;
        r2 = 32'h9E37_79B9;
        for (int k = 0; k < 100; k++) begin
            r1 ^= r1 << 13; r1 ^= r1 >> 17; r1 ^= r1 << 5;
            r2 ^= r2 << 13; r2 ^= r2 >> 17; r2 ^= r2 << 5;
            w = (r1 & ~32'h0022_AAAA) | (r1 & r2 & 32'h0022_AAAA);
            sweep(w, "R6 random sweep");
        end

        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule